// File: doc/BRIEF.md
# Channel Register Bank Behind an I2C Target

This block is an I2C target that gives a host access to a small bank of 8-bit per-channel control registers. The SCL and SDA lines are open-drain. Both are brought into the system clock domain through a two-flop synchroniser. Start and stop conditions are decoded from the synchronised lines. The block answers to a 7-bit address. A parameter fixes the five upper bits of that address, and two strap inputs set the two lowest bits.

A write transaction carries three things in order: the address byte with the direction bit at 0, a sub-address byte that picks a channel, and optionally data bytes that are stored into that channel. The sub-address is held in a pointer register, and a stop condition does not clear it. A read therefore takes two transactions. The first is a short write that sets the pointer and ends with a stop. The second is a read transaction that returns one byte from the selected channel. The master ends the read with a not-acknowledge and a stop. To read several channels, the host repeats this pair of transactions for each channel.

Top module: `chanreg_i2c_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth SCL clock) an address byte whose upper seven bits equal {ADDR_UPPER, addr_strap}. ADDR_UPPER is the high part, and bit 0 of the byte is the direction (0 = write, 1 = read).
- R2: After an address byte that does not match, the target does not acknowledge and never pulls SDA low until the next start condition.
- R3: In a write transaction, the byte after the address is the sub-address. A value below NUM_CH is acknowledged and stored as the pointer, and the pointer keeps its value across stop conditions.
- R4: A sub-address of NUM_CH or above is not acknowledged and leaves the pointer unchanged. The bytes that follow it in the same transaction are neither acknowledged nor stored.
- R5: Each data byte after an accepted sub-address in the same write transaction is acknowledged and written into the selected channel. Channel c appears on reg_bank_q bits [8c+7:8c].
- R6: In a read transaction whose address matches, the target shifts out the byte of the channel selected by the pointer, MSB first, starting right after the address acknowledge.
- R7: After the master's not-acknowledge and a stop, the target has released SDA and is idle.
- R8: The target changes its SDA drive only while SCL is low.
- R9: A start condition in the middle of a byte resets the bit count, and a complete address byte then follows normally.
- R10: Reset (rst_n low at a clock edge) releases SDA and clears every channel register to 0x00 and the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| addr_strap | input | 2 | Two lowest address bits, tied high or low |
| sda_pull_low | output | 1 | 1 drives the SDA line low, 0 releases it |
| reg_bank_q | output | NUM_CH*8 | Contents of all channel registers, channel 0 in the low byte |

## Verification
The bench addresses the target with a byte that differs only in the strap bits. A design that ignored the straps would acknowledge that byte or latch the byte after it as a sub-address. Sub-addresses at and above NUM_CH are sent, followed by a read without a new pointer write. A design that loaded the pointer before range-checking it, or cleared the pointer on stop, would return the wrong channel. A start is inserted after three bits of a byte. A bit counter that survives the start would misalign the following address and drop the write. The bench also watches every change of the SDA drive against the SCL level, and checks that SDA is released after the closing not-acknowledge and stop.

// File: rtl/chanreg_i2c_pkg.sv
// Package chanreg_i2c_pkg
// Shared constants and the protocol state type for the channel-register
// I2C target. Assumes byte-wide registers throughout.
package chanreg_i2c_pkg;

    localparam int BYTE_W = 8;

    // Protocol phases of the target engine
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction in progress
        ST_ADDR,   // shifting in the address byte
        ST_SUB,    // shifting in the sub-address byte
        ST_WDATA,  // shifting in a data byte
        ST_ACK,    // holding SDA low through the ninth clock
        ST_TX,     // shifting out a register byte
        ST_MACK,   // waiting for the master's (not-)acknowledge
        ST_SKIP    // ignoring the bus until start or stop
    } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module i2c_line_sync
// Brings SCL and SDA into the clock domain through a STAGES-deep
// synchroniser and decodes SCL edges plus start and stop conditions.
// Assumes both lines idle high; the reset value matches an idle bus.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Purpose: synchronise both lines and keep one extra delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Purpose: decode edges and bus conditions from current and delayed levels
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/chanreg_i2c_fsm.sv
// Module chanreg_i2c_fsm
// Bit-level receive/transmit engine of the target. Samples data on SCL
// rising edges and changes its SDA drive only after SCL falling edges.
// Holds the sub-address pointer, which survives stop conditions.
// Assumes no clock stretching and 7-bit addressing only.
module chanreg_i2c_fsm
    import chanreg_i2c_pkg::*;
#(
    parameter int          NUM_CH     = 4,
    parameter logic [4:0]  ADDR_UPPER = 5'b01011,
    parameter int          PTR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [PTR_W-1:0]  ptr
);

    localparam logic [BYTE_W-1:0] CH_LIMIT = BYTE_W'(NUM_CH);
    localparam logic [3:0]        BITS_PER = 4'd8;

    phase_t            state;
    phase_t            ack_next;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        cnt;

    // Purpose: protocol sequencing, shifting, acknowledge and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_byte  <= '0;
            ptr      <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BITS_PER) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == {ADDR_UPPER, addr_strap}) begin
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                    ack_next <= shreg[0] ? ST_TX : ST_SUB;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_SUB) begin
                                if (shreg < CH_LIMIT) begin
                                    ptr      <= shreg[PTR_W-1:0];
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                    ack_next <= ST_WDATA;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                wr_en    <= 1'b1;
                                wr_byte  <= shreg;
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK;
                                ack_next <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= ack_next;
                            cnt   <= '0;
                            if (ack_next == ST_TX) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == BITS_PER) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the SDA drive moves only while the synchronised SCL is low
    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R7: a stop condition leaves SDA released and the engine idle
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));

    // R2: while skipping the bus the target never drives SDA
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R3: the pointer changes only when a sub-address byte completes
    p_ptr_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ($past(state) == ST_SUB && $past(scl_fall)));

endmodule

// File: rtl/chanreg_bank.sv
// Module chanreg_bank
// NUM_CH byte registers, written one at a time at the pointer and read
// combinationally at the same pointer. Assumes ptr stays below NUM_CH.
module chanreg_bank
    import chanreg_i2c_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PTR_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PTR_W-1:0]         ptr,
    input  logic [BYTE_W-1:0]        wr_byte,
    output logic [BYTE_W-1:0]        rd_byte,
    output logic [NUM_CH*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Purpose: hold one channel byte, loaded when selected and written
        always_ff @(posedge clk) begin
            if (!rst_n)                                    regs[ch] <= '0;
            else if (wr_en && ptr == PTR_W'(ch))           regs[ch] <= wr_byte;
        end
        assign regs_flat[ch*BYTE_W +: BYTE_W] = regs[ch];
    end

    // Purpose: present the selected channel to the transmit path
    assign rd_byte = regs[ptr];

    // R5: a write strobe lands its byte in the selected channel
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(ptr)] == $past(wr_byte)));

endmodule

// File: rtl/chanreg_i2c_target.sv
// Module chanreg_i2c_target
// Top of the I2C channel-register target: line synchroniser, protocol
// engine and register bank. sda_pull_low must drive an open-drain pad;
// sda_i must be the resolved line level.
module chanreg_i2c_target
    import chanreg_i2c_pkg::*;
#(
    parameter int         NUM_CH      = 4,
    parameter logic [4:0] ADDR_UPPER  = 5'b01011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic [1:0]               addr_strap,
    output logic                     sda_pull_low,
    output logic [NUM_CH*BYTE_W-1:0] reg_bank_q
);

    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte, rd_byte;
    logic [PTR_W-1:0]  ptr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    chanreg_i2c_fsm #(.NUM_CH(NUM_CH), .ADDR_UPPER(ADDR_UPPER), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_strap(addr_strap), .rd_byte(rd_byte),
        .sda_oe(sda_pull_low), .wr_en(wr_en), .wr_byte(wr_byte), .ptr(ptr)
    );

    chanreg_bank #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr),
        .wr_byte(wr_byte), .rd_byte(rd_byte), .regs_flat(reg_bank_q)
    );

endmodule

// File: tb/chanreg_i2c_target_tb.sv
module chanreg_i2c_target_tb;

    localparam int         NUM_CH = 4;
    localparam int         Q      = 10;
    localparam logic [6:0] MY_ADDR = {5'b01011, 2'b10};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_line = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_pull_low;
    logic [31:0] reg_bank_q;
    logic        sda_bus;

    int tests = 0;
    int fails = 0;
    int oe_viol = 0;
    logic oe_seen = 1'b0;
    logic oe_prev = 1'b0;

    // scoreboard queues
    string exp_tag[$];
    int    exp_val[$];
    int    obs_val[$];

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull_low;

    chanreg_i2c_target #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_bus),
        .addr_strap(2'b10), .sda_pull_low(sda_pull_low), .reg_bank_q(reg_bank_q)
    );

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(string tag, int v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    // monitor: pops observations and compares against expected items
    always @(negedge clk) begin
        if (obs_val.size() > 0 && exp_val.size() > 0) begin
            check(exp_tag.pop_front(), obs_val.pop_front(), exp_val.pop_front());
        end
    end

    // monitor for R8 and for silent-bus windows
    always @(negedge clk) begin
        if (sda_pull_low != oe_prev && scl_line) oe_viol++;
        if (sda_pull_low) oe_seen = 1'b1;
        oe_prev <= sda_pull_low;
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(); scl_line = 1'b1; wait_q();
        m_sda = 1'b0; wait_q(); scl_line = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(); scl_line = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wait_q(); scl_line = 1'b1; wait_q(); wait_q();
        scl_line = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wait_q(); scl_line = 1'b1; wait_q();
        b = sda_bus; wait_q(); scl_line = 1'b0; wait_q();
    endtask

    // sends a byte and records the acknowledge bit (0 = ack, 1 = nack)
    task automatic put_byte(input logic [7:0] b);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        obs_val.push_back(int'(a));
    endtask

    // receives a byte, records it, and answers with a not-acknowledge
    task automatic get_byte();
        logic [7:0] d;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(1'b1);
        obs_val.push_back(int'(d));
    endtask

    task automatic do_write(input logic [7:0] ch, input logic [7:0] data);
        bus_start();
        expect_item("R1 write address ack", 0); put_byte({MY_ADDR, 1'b0});
        expect_item("R3 sub-address ack", 0);   put_byte(ch);
        expect_item("R5 data ack", 0);          put_byte(data);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] ch, input int ack);
        bus_start();
        expect_item("R1 write address ack", 0); put_byte({MY_ADDR, 1'b0});
        expect_item(ack == 0 ? "R3 sub-address ack" : "R4 out-of-range nack", ack);
        put_byte(ch);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] exp_data);
        bus_start();
        expect_item("R1 read address ack", 0); put_byte({MY_ADDR, 1'b1});
        expect_item("R6 read data", int'(exp_data)); get_byte();
        bus_stop();
        wait_q();
        check("R7 SDA released after nack and stop", int'(sda_pull_low), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 reset SDA released", int'(sda_pull_low), 0);
        check("R10 reset registers clear", int'(reg_bank_q), 0);
        wait_q();

        // R5: writes into several channels
        do_write(8'd2, 8'hA5);
        check("R5 channel 2 written", int'(reg_bank_q), 32'h00A5_0000);
        do_write(8'd0, 8'h3C);
        do_write(8'd3, 8'h81);
        check("R5 channels 0,2,3 written", int'(reg_bank_q), 32'h81A5_003C);

        // R3, R6: pointer set by separate write survives the stop
        set_ptr(8'd3, 0);
        do_read(8'h81);
        set_ptr(8'd0, 0);
        do_read(8'h3C);
        set_ptr(8'd2, 0);
        do_read(8'hA5);

        // R2: strap bits mismatch, no ack and no drive until next start
        oe_seen = 1'b0;
        bus_start();
        expect_item("R2 mismatched address nack", 1); put_byte({5'b01011, 2'b01, 1'b0});
        expect_item("R2 following byte ignored", 1);  put_byte(8'd1);
        expect_item("R2 following byte ignored", 1);  put_byte(8'h77);
        bus_stop();
        check("R2 SDA never driven", int'(oe_seen), 0);
        check("R2 registers untouched", int'(reg_bank_q), 32'h81A5_003C);

        // R4: out-of-range sub-addresses, pointer kept at channel 2
        set_ptr(8'd4, 1);
        set_ptr(8'hF0, 1);
        bus_start();
        expect_item("R1 write address ack", 0); put_byte({MY_ADDR, 1'b0});
        expect_item("R4 out-of-range nack", 1); put_byte(8'd5);
        expect_item("R4 trailing data nack", 1); put_byte(8'hEE);
        bus_stop();
        check("R4 registers untouched", int'(reg_bank_q), 32'h81A5_003C);
        do_read(8'hA5);

        // R9: start after three bits of a byte restarts the address
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_write(8'd1, 8'h42);
        check("R9 write after aborted byte", int'(reg_bank_q), 32'h81A5_423C);
        set_ptr(8'd1, 0);
        do_read(8'h42);

        // drain the scoreboard
        repeat (4) @(negedge clk);
        check("scoreboard drained (R1)", exp_val.size() + obs_val.size(), 0);
        check("R8 SDA changes only while SCL low", oe_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule